// File: doc/BRIEF.md
# Input Edge Mask Timer

This block cleans up an edge-event stream coming from a frequency-generator sensor. When an input edge arrives and no blanking is in progress, the edge is forwarded at once and a blanking window opens. Until the window closes, every further edge is dropped. This removes contact bounce, ringing and doubled pulses before they reach a downstream divider.

The length of the window is `(P + 1) x D` system clocks:

- `P` is a 6-bit value held in a write-only period register.
- `D` is a prescaler ratio picked by a 2-bit select: 1, 4, 16 or 64.

Writing the register also reloads the live down counter and restarts the prescaler in the same clock. Software can therefore stretch or shorten a window that is already running. A standby input returns the block to its power-on state: maximum period and no blanking.

Top module: `edge_mask_timer`

## Requirements
- R1: After reset `mask_o` and `edge_o` are 0 and the stored period is 63. The first accepted edge with select 0 gives a 64-cycle mask.
- R2: A write with `wr_en_i` stores `wr_data_i[5:0]` as the period. Bits 7:6 of the write data have no effect.
- R3: An `edge_i` pulse in a cycle where `mask_o` is 0 and standby is low appears on `edge_o` in that same cycle.
- R4: The cycle after an accepted edge, `mask_o` rises. It stays high for exactly `(P+1) x D` cycles, where `P` is the stored period and `D` is the prescaler ratio.
- R5: An edge arriving while `mask_o` is 1 never reaches `edge_o` and does not lengthen the window.
- R6: Select encoding 0, 1, 2, 3 gives prescaler ratio 1, 4, 16, 64 respectively.
- R7: A write during an active window reloads the counter and restarts the prescaler. `mask_o` then stays high for `(Pnew+1) x D` cycles after the write cycle.
- R8: While `standby_i` is high, edges are blocked and the period returns to 63. `mask_o` is 0 from the cycle after standby is first seen. Standby takes priority over writes.
- R9: A stored period of 0 gives a window of exactly one prescaled clock, `D` cycles.
- R10: When a write and an accepted edge share a cycle, the window uses the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Synchronous low-power request; reinitialises the block |
| wr_en_i | input | 1 | Write strobe for the period register |
| wr_data_i | input | 8 | Write data; bits 5:0 hold the period value |
| clk_sel_i | input | 2 | Prescaler select: 0 to 3 give /1, /4, /16, /64 |
| edge_i | input | 1 | One-cycle input edge event |
| edge_o | output | 1 | Filtered edge event |
| mask_o | output | 1 | High while the blanking window is open |

## Verification
The bench targets the exact window length for every prescaler ratio and for a period of 0. An off-by-one in the N-1 coding, or a prescaler that keeps its old phase, would show up as windows one count long or short. It holds the edge input high for the whole window, including the final masked cycle; a design that let the window extend, or opened it one cycle early, would pass an extra edge or produce a second run. It also fires a write in mid-window and a write together with an edge, which shows whether the reload takes the new value and whether the prescaler restarts. Finally it checks that standby both closes a window and restores the 63 default that is only visible through the next window's length.

// File: rtl/emt_pkg.sv
package emt_pkg;

  localparam int unsigned EMT_PERIOD_W = 6;
  localparam int unsigned EMT_SEL_W    = 2;

  // Counter value to load: a write takes priority over the stored period.
  function automatic logic [EMT_PERIOD_W-1:0] pick_load(
    input logic                    wr_en,
    input logic [EMT_PERIOD_W-1:0] wr_val,
    input logic [EMT_PERIOD_W-1:0] stored
  );
    return wr_en ? wr_val : stored;
  endfunction

  // One step of the blanking down counter.
  function automatic logic [EMT_PERIOD_W-1:0] step_down(
    input logic [EMT_PERIOD_W-1:0] cur
  );
    return cur - {{(EMT_PERIOD_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/emt_prescaler.sv
module emt_prescaler #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned NUM_SEL = 1 << SEL_W,
  localparam int unsigned CNT_W   = 2 * (NUM_SEL - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_SEL-1:0] tick_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  // Select i divides by 4**i: tick when the low 2*i bits are all ones.
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_tap
    if (i == 0) begin : g_div1
      assign tick_vec[i] = 1'b1;
    end else begin : g_divn
      assign tick_vec[i] = &cnt_q[2*i-1:0];
    end
  end

  assign tick = tick_vec[sel];

endmodule

// File: rtl/emt_period_reg.sv
module emt_period_reg #(
  parameter int unsigned PERIOD_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                standby,
  input  logic                wr_en,
  input  logic [PERIOD_W-1:0] wr_val,
  output logic [PERIOD_W-1:0] period_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       period_q <= '1;
    else if (standby) period_q <= '1;
    else if (wr_en)   period_q <= wr_val;
  end

endmodule

// File: rtl/emt_blank_counter.sv
module emt_blank_counter #(
  parameter int unsigned PERIOD_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                standby,
  input  logic                load,
  input  logic                open_win,
  input  logic [PERIOD_W-1:0] load_val,
  input  logic [PERIOD_W-1:0] reload_val,
  input  logic                tick,
  output logic [PERIOD_W-1:0] cnt_q,
  output logic                mask_q,
  output logic                underflow
);

  assign underflow = mask_q && tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      mask_q <= 1'b0;
    end else if (standby) begin
      cnt_q  <= '1;
      mask_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      if (open_win) mask_q <= 1'b1;
    end else if (underflow) begin
      cnt_q  <= reload_val;
      mask_q <= 1'b0;
    end else if (mask_q && tick) begin
      cnt_q <= emt_pkg::step_down(cnt_q);
    end
  end

endmodule

// File: rtl/edge_mask_timer.sv
module edge_mask_timer #(
  parameter int unsigned PERIOD_W = emt_pkg::EMT_PERIOD_W,
  parameter int unsigned SEL_W    = emt_pkg::EMT_SEL_W,
  parameter int unsigned DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  clk_sel_i,
  input  logic              edge_i,
  output logic              edge_o,
  output logic              mask_o
);

  logic [PERIOD_W-1:0] wr_val;
  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] load_val;
  logic                accept;
  logic                wr_take;
  logic                load;
  logic                tick;
  logic                underflow;
  logic                mask_q;
  logic                unused_hi;

  assign wr_val    = wr_data_i[PERIOD_W-1:0];
  assign unused_hi = ^wr_data_i[DATA_W-1:PERIOD_W];

  // Named internal events, also used by the bound checker.
  assign accept   = edge_i && !mask_q && !standby_i;
  assign wr_take  = wr_en_i && !standby_i;
  assign load     = accept || wr_take;
  assign load_val = emt_pkg::pick_load(wr_take, wr_val, period_q);

  emt_period_reg #(.PERIOD_W(PERIOD_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby_i),
    .wr_en    (wr_en_i),
    .wr_val   (wr_val),
    .period_q (period_q)
  );

  emt_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load || standby_i),
    .sel     (clk_sel_i),
    .tick    (tick)
  );

  emt_blank_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby    (standby_i),
    .load       (load),
    .open_win   (accept),
    .load_val   (load_val),
    .reload_val (period_q),
    .tick       (tick),
    .cnt_q      (cnt_q),
    .mask_q     (mask_q),
    .underflow  (underflow)
  );

  assign edge_o = accept;
  assign mask_o = mask_q;

endmodule

// File: rtl/emt_checker.sv
module emt_checker #(
  parameter int unsigned PERIOD_W = 6,
  parameter int unsigned DATA_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                standby_i,
  input logic                wr_en_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic                edge_o,
  input logic                mask_o,
  input logic [PERIOD_W-1:0] cnt_q,
  input logic [PERIOD_W-1:0] period_q,
  input logic                underflow
);

  // R5
  edge_blocked_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> !mask_o);

  // R4
  mask_opens_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> mask_o);

  // R4
  mask_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_o) |-> $past(edge_o));

  // R4
  mask_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mask_o) |-> ($past(underflow) || $past(standby_i)));

  // R8
  standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (!mask_o && period_q == '1));

  // R2
  write_loads_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !standby_i) |=> (cnt_q == $past(wr_data_i[PERIOD_W-1:0])
                                 && period_q == cnt_q));

  // R7
  count_within_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= period_q);

endmodule

bind edge_mask_timer emt_checker #(.PERIOD_W(PERIOD_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .standby_i (standby_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .edge_o    (edge_o),
  .mask_o    (mask_o),
  .cnt_q     (cnt_q),
  .period_q  (period_q),
  .underflow (underflow)
);

// File: tb/tb_edge_mask_timer.sv
`timescale 1ns/100ps
module tb_edge_mask_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] clk_sel_i = '0;
  logic       edge_i = 1'b0;
  logic       edge_o;
  logic       mask_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];
  int run_len = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  edge_mask_timer dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .clk_sel_i(clk_sel_i), .edge_i(edge_i),
    .edge_o(edge_o), .mask_o(mask_o)
  );

  // Window length from the requirement: (P+1) times 4**sel.
  function automatic int win_len(input int p, input int sel);
    int d = 1;
    for (int k = 0; k < sel; k++) d = d * 4;
    return (p + 1) * d;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_run(input int len, input string tag);
    exp_q.push_back(len);
    tag_q.push_back(tag);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic pulse(input bit pass, input string tag);
    @(negedge clk); edge_i = 1'b1;
    #0.5 check(edge_o == pass, tag, edge_o, pass);
    @(negedge clk); edge_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mask_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: measure each mask run and compare with the scoreboard.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (mask_o) run_len++;
      else if (run_len > 0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected mask run", run_len, 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(run_len == e, t, run_len, e);
        end
        run_len = 0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5 check(mask_o == 1'b0, "R1 reset mask", mask_o, 0);
    check(edge_o == 1'b0, "R1 reset edge_o", edge_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1, R3: default period 63, select 0
    expect_run(win_len(63, 0), "R1 default window");
    pulse(1'b1, "R3 edge passes");
    wait_idle();

    // R2: upper bits ignored, 0xC5 -> period 5
    do_write(8'hC5);
    expect_run(win_len(5, 0), "R2 write period");
    pulse(1'b1, "R3 edge passes");
    wait_idle();

    // R6: other prescaler ratios with period 5
    for (int s = 1; s < 4; s++) begin
      clk_sel_i = s[1:0];
      expect_run(win_len(5, s), "R6 prescaler ratio");
      pulse(1'b1, "R6 edge passes");
      wait_idle();
    end

    // R9: period 0 with /1 and /4
    do_write(8'h00);
    clk_sel_i = 2'd0;
    expect_run(win_len(0, 0), "R9 period zero /1");
    pulse(1'b1, "R9 edge passes");
    wait_idle();
    clk_sel_i = 2'd1;
    expect_run(win_len(0, 1), "R9 period zero /4");
    pulse(1'b1, "R9 edge passes");
    wait_idle();

    // R5: edge held high through the whole window
    clk_sel_i = 2'd0;
    do_write(8'd9);
    expect_run(10, "R5 window not extended");
    @(negedge clk); edge_i = 1'b1;
    #0.5 check(edge_o == 1'b1, "R5 first edge passes", edge_o, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      #0.5 check(edge_o == 1'b0, "R5 masked edge dropped", edge_o, 0);
    end
    @(negedge clk); edge_i = 1'b0;
    wait_idle();

    // R7: write 3 five cycles into a period-20 window -> 5 + 4 = 9
    do_write(8'd20);
    expect_run(9, "R7 mid-window reload");
    pulse(1'b1, "R7 edge passes");
    repeat (4) @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = 8'd3;
    @(negedge clk); wr_en_i = 1'b0;
    wait_idle();

    // R10: write 2 together with an edge -> 3 cycles
    expect_run(3, "R10 write with edge");
    @(negedge clk); edge_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'd2;
    #0.5 check(edge_o == 1'b1, "R10 edge passes", edge_o, 1);
    @(negedge clk); edge_i = 1'b0; wr_en_i = 1'b0;
    wait_idle();

    // R8: standby three cycles into a period-40 window -> run of 3
    do_write(8'd40);
    expect_run(3, "R8 standby closes window");
    pulse(1'b1, "R8 edge passes");
    repeat (2) @(negedge clk);
    standby_i = 1'b1; edge_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'd1;
    #0.5 check(edge_o == 1'b0, "R8 edge blocked in standby", edge_o, 0);
    @(negedge clk);
    #0.5 check(edge_o == 1'b0, "R8 edge blocked in standby", edge_o, 0);
    check(mask_o == 1'b0, "R8 mask cleared", mask_o, 0);
    @(negedge clk); standby_i = 1'b0; edge_i = 1'b0; wr_en_i = 1'b0;
    wait_idle();
    expect_run(win_len(63, 0), "R8 period back to 63");
    pulse(1'b1, "R8 edge passes after standby");
    wait_idle();

    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule